// File: doc/BRIEF.md
# Entropy Source Gating Controller

This block sits between a physically derived entropy source and the random generator that seeds an AES engine. It decides, cycle by cycle, whether entropy words may pass to the consumer. It also decides whether the chip may finish booting. Two conditions must both hold. First, the one-shot power-up health test of the entropy source has reported a pass. Second, the measured die temperature is strictly above a programmable cold limit. Below that limit the source's output depends on stale cell contents and not on manufacturing variation.

The cold limit sits in a register inside the block. Every write carries the identity of the agent that issued it. Only agents marked as members of the root of trust in a parameter mask can change the limit. A write from any other agent leaves the limit untouched and raises a sticky violation flag. After reset the controller waits for the test verdict. A failing verdict locks it in a failed state until the next reset. A passing verdict moves it to checking temperature, and it opens the gate whenever the die is warm enough.

Top module: `entropy_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it: entValid=0, entData=0 and bootEnable=0. violation is 0 and threshold equals the parameter THRESH_RST (default 100).
- R2: After reset the controller waits for testDone. Until testDone is seen, entValid and bootEnable stay 0 whatever the temperature is.
- R3: If testDone arrives with testPass=0, the controller enters a failed state it never leaves before reset. In that state bootEnable and entValid stay 0 and entData stays 0 at any temperature.
- R4: After a passing test, bootEnable rises one cycle after a cycle in which tempReading > threshold. The compare is unsigned and strict, so tempReading equal to threshold counts as too cold.
- R5: Whenever the gate is shut, entData is all zeros and entValid is 0.
- R6: While enabled and warm, entValid and entData repeat rawValid and rawData with one cycle of latency. A cycle with rawValid=0 gives entValid=0 and entData=0.
- R7: If tempReading drops to or below threshold while enabled, the output is gated on the next cycle and bootEnable falls. The gate reopens once the reading is above threshold again.
- R8: A write (cfgWrEn=1) from an agent whose bit cfgAgent in TRUST_MASK is 1 loads cfgWrData into threshold on the next cycle. The default mask trusts agents 0 and 1 of 8.
- R9: A write from an agent whose mask bit is 0 leaves threshold unchanged. It sets violation, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempReading | input | TEMP_W | Unsigned die temperature code |
| cfgWrEn | input | 1 | Write strobe for the cold limit |
| cfgAgent | input | AGENT_W | Identity of the writing agent |
| cfgWrData | input | TEMP_W | New cold limit value |
| testDone | input | 1 | Power-up health test verdict strobe |
| testPass | input | 1 | Verdict, sampled with testDone |
| rawValid | input | 1 | Entropy word valid from the source |
| rawData | input | DATA_W | Entropy word from the source |
| threshold | output | TEMP_W | Current cold limit |
| violation | output | 1 | Sticky flag for a refused write |
| entValid | output | 1 | Entropy word valid to the consumer |
| entData | output | DATA_W | Entropy word to the consumer, zero when gated |
| bootEnable | output | 1 | Boot may proceed |

## Verification
The assertions watch, on every cycle, that a failed state never ends before reset. They also check that the controller stays in the test wait until a verdict arrives and that boot only rises after a warm cycle. Finally they check that a cold reading shuts the output one cycle later, that shut output carries zero data, and that writes load or keep the limit according to the agent's trust and keep the violation flag sticky. The full order of a session can only be shown by the bench's scenarios. These cover the equal-temperature boundary, reopening after a cold spell, the way a trusted raise of the limit cuts off a running stream, and the clearing of all state by a second reset.

// File: rtl/entropy_gate_pkg.sv
package entropy_gate_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_WAIT_TEST,
    ST_CHECK,
    ST_ENABLED,
    ST_FAIL
  } gateState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic gateOpen;   // state allows entropy to pass
    logic holdFail;   // locked-out state, datapath forces zeros
  } ctrlStrobes_t;

endpackage

// File: rtl/entropy_gate_ctrl.sv
module entropy_gate_ctrl
  import entropy_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         testDone,
  input  logic         testPass,
  input  logic         warm,
  output ctrlStrobes_t strobes,
  output logic         bootEnable
);

  gateState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RESET:     stateNext = ST_WAIT_TEST;
      ST_WAIT_TEST: if (testDone) stateNext = testPass ? ST_CHECK : ST_FAIL;
      ST_CHECK:     if (warm) stateNext = ST_ENABLED;
      ST_ENABLED:   if (!warm) stateNext = ST_CHECK;
      ST_FAIL:      stateNext = ST_FAIL;
      default:      stateNext = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= stateNext;
  end

  assign strobes.gateOpen = (state == ST_ENABLED);
  assign strobes.holdFail = (state == ST_FAIL);
  assign bootEnable       = (state == ST_ENABLED);

  // R3: the failed state is terminal until reset
  assert_fail_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAIL) |=> (state == ST_FAIL));

  // R2: no verdict, no progress
  assert_wait_for_test_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_TEST && !testDone) |=> (state == ST_WAIT_TEST));

  // R4: boot only rises after a warm cycle
  assert_boot_needs_warm_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bootEnable) |-> $past(warm));

endmodule

// File: rtl/entropy_gate_path.sv
module entropy_gate_path
  import entropy_gate_pkg::*;
#(
  parameter int TEMP_W  = 10,
  parameter int DATA_W  = 32,
  parameter int AGENT_W = 3,
  parameter logic [(1<<AGENT_W)-1:0] TRUST_MASK = 'h3,
  parameter logic [TEMP_W-1:0] THRESH_RST = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [TEMP_W-1:0] tempReading,
  input  logic              cfgWrEn,
  input  logic [AGENT_W-1:0] cfgAgent,
  input  logic [TEMP_W-1:0] cfgWrData,
  input  logic              rawValid,
  input  logic [DATA_W-1:0] rawData,
  output logic              warm,
  output logic [TEMP_W-1:0] threshold,
  output logic              violation,
  output logic              entValid,
  output logic [DATA_W-1:0] entData
);

  localparam int AGENT_N = 1 << AGENT_W;

  logic [AGENT_N-1:0] trustVec;
  logic               agentTrusted;
  logic               passNow;

  assign trustVec     = TRUST_MASK;
  assign agentTrusted = trustVec[cfgAgent];

  // unsigned strict compare: equal is too cold
  assign warm    = (tempReading > threshold);
  assign passNow = strobes.gateOpen && !strobes.holdFail && warm && rawValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      threshold <= THRESH_RST;
      violation <= 1'b0;
    end else if (cfgWrEn) begin
      if (agentTrusted) threshold <= cfgWrData;
      else              violation <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= 1'b0;
      entData  <= '0;
    end else begin
      entValid <= passNow;
      entData  <= passNow ? rawData : '0;
    end
  end

  // R5: gated output carries no data
  assert_gated_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !entValid |-> (entData == '0));

  // R7: cold reading shuts the output on the next cycle
  assert_cold_gates_R7: assert property (@(posedge clk) disable iff (!rstN)
    !warm |=> !entValid);

  // R8: trusted write lands
  assert_trusted_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && agentTrusted) |=> (threshold == $past(cfgWrData)));

  // R9: untrusted write leaves the limit alone and flags
  assert_untrusted_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !agentTrusted) |=> ($stable(threshold) && violation));

  assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);

endmodule

// File: rtl/entropy_gate.sv
module entropy_gate
  import entropy_gate_pkg::*;
#(
  parameter int TEMP_W  = 10,
  parameter int DATA_W  = 32,
  parameter int AGENT_W = 3,
  parameter logic [(1<<AGENT_W)-1:0] TRUST_MASK = 'h3,
  parameter logic [TEMP_W-1:0] THRESH_RST = 100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TEMP_W-1:0]  tempReading,
  input  logic               cfgWrEn,
  input  logic [AGENT_W-1:0] cfgAgent,
  input  logic [TEMP_W-1:0]  cfgWrData,
  input  logic               testDone,
  input  logic               testPass,
  input  logic               rawValid,
  input  logic [DATA_W-1:0]  rawData,
  output logic [TEMP_W-1:0]  threshold,
  output logic               violation,
  output logic               entValid,
  output logic [DATA_W-1:0]  entData,
  output logic               bootEnable
);

  ctrlStrobes_t strobes;
  logic         warm;

  entropy_gate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .testDone   (testDone),
    .testPass   (testPass),
    .warm       (warm),
    .strobes    (strobes),
    .bootEnable (bootEnable)
  );

  entropy_gate_path #(
    .TEMP_W     (TEMP_W),
    .DATA_W     (DATA_W),
    .AGENT_W    (AGENT_W),
    .TRUST_MASK (TRUST_MASK),
    .THRESH_RST (THRESH_RST)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .tempReading (tempReading),
    .cfgWrEn     (cfgWrEn),
    .cfgAgent    (cfgAgent),
    .cfgWrData   (cfgWrData),
    .rawValid    (rawValid),
    .rawData     (rawData),
    .warm        (warm),
    .threshold   (threshold),
    .violation   (violation),
    .entValid    (entValid),
    .entData     (entData)
  );

endmodule

// File: tb/entropy_gate_bench.sv
module entropy_gate_bench;

  localparam int TW = 10;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam logic [7:0] MASK = 8'h03;
  localparam logic [TW-1:0] THR0 = 100;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [TW-1:0] tempReading = '0;
  logic          cfgWrEn = 1'b0;
  logic [AW-1:0] cfgAgent = '0;
  logic [TW-1:0] cfgWrData = '0;
  logic          testDone = 1'b0;
  logic          testPass = 1'b0;
  logic          rawValid = 1'b0;
  logic [DW-1:0] rawData = '0;
  logic [TW-1:0] threshold;
  logic          violation;
  logic          entValid;
  logic [DW-1:0] entData;
  logic          bootEnable;

  always #4 clk = ~clk;  // 125 MHz

  entropy_gate u_entropy_gate (
    .clk(clk), .rstN(rstN), .tempReading(tempReading), .cfgWrEn(cfgWrEn),
    .cfgAgent(cfgAgent), .cfgWrData(cfgWrData), .testDone(testDone),
    .testPass(testPass), .rawValid(rawValid), .rawData(rawData),
    .threshold(threshold), .violation(violation), .entValid(entValid),
    .entData(entData), .bootEnable(bootEnable)
  );

  typedef struct {
    string         tag;
    logic          v;
    logic [DW-1:0] d;
    logic          b;
    logic [TW-1:0] t;
    logic          viol;
  } exp_t;

  exp_t expQ[$];
  int   errors = 0;
  int   checks = 0;

  // reference model state: 0 reset,1 wait,2 check,3 enabled,4 failed
  int            mState = 0;
  logic [TW-1:0] mThr = THR0;
  logic          mViol = 1'b0;

  task automatic cmp(string tag, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic modelReset();
    mState = 0; mThr = THR0; mViol = 1'b0;
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic drive(string tag, int temp, bit wr, int agent, int wdata,
                       bit done, bit pass, bit rv, logic [DW-1:0] rd);
    exp_t e;
    bit   w;
    int   nxt;
    @(negedge clk);
    tempReading = TW'(temp); cfgWrEn = wr; cfgAgent = AW'(agent);
    cfgWrData = TW'(wdata); testDone = done; testPass = pass;
    rawValid = rv; rawData = rd;
    w = (TW'(temp) > mThr);
    e.tag = tag;
    e.v = (mState == 3) && w && rv;
    e.d = e.v ? rd : '0;
    case (mState)
      0: nxt = 1;
      1: nxt = done ? (pass ? 2 : 4) : 1;
      2: nxt = w ? 3 : 2;
      3: nxt = w ? 3 : 2;
      default: nxt = 4;
    endcase
    if (wr) begin
      if (MASK[agent]) mThr = TW'(wdata);
      else mViol = 1'b1;
    end
    mState = nxt;
    e.b = (nxt == 3);
    e.t = mThr;
    e.viol = mViol;
    expQ.push_back(e);
  endtask

  // monitor: samples after each rising edge and compares with the queue
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        cmp(e.tag, "entValid", longint'(entValid), longint'(e.v));
        cmp(e.tag, "entData", longint'(entData), longint'(e.d));
        cmp(e.tag, "bootEnable", longint'(bootEnable), longint'(e.b));
        cmp(e.tag, "threshold", longint'(threshold), longint'(e.t));
        cmp(e.tag, "violation", longint'(violation), longint'(e.viol));
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    cfgWrEn = 1'b0; testDone = 1'b0; rawValid = 1'b0;
    modelReset();
    @(negedge clk);
    // R1: reset values
    cmp("R1", "entValid", longint'(entValid), 0);
    cmp("R1", "entData", longint'(entData), 0);
    cmp("R1", "bootEnable", longint'(bootEnable), 0);
    cmp("R1", "violation", longint'(violation), 0);
    cmp("R1", "threshold", longint'(threshold), longint'(THR0));
    rstN = 1'b1;
  endtask

  initial begin
    applyReset();
    // R1: first cycle after reset, warm with data present
    drive("R1", 500, 0, 0, 0, 0, 0, 1, 32'hAAAA_5555);
    // R2: no verdict yet, hot and data offered
    for (int i = 0; i < 4; i++) drive("R2", 900, 0, 0, 0, 0, 0, 1, 32'h1000 + i);
    // R4: passing verdict while temperature equals the limit
    drive("R4", 100, 0, 0, 0, 1, 1, 1, 32'hDEAD_BEEF);
    drive("R4", 100, 0, 0, 0, 0, 0, 1, 32'h1234_5678);
    drive("R5", 100, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    // R4: one above the limit
    drive("R4", 101, 0, 0, 0, 0, 0, 1, 32'h0BAD_F00D);
    // R6: stream passes, including idle cycles
    drive("R6", 101, 0, 0, 0, 0, 0, 1, 32'hCAFE_0001);
    drive("R6", 300, 0, 0, 0, 0, 0, 0, 32'hCAFE_0002);
    drive("R6", 300, 0, 0, 0, 0, 0, 1, 32'h8000_0000);
    drive("R6", 1023, 0, 0, 0, 0, 0, 1, 32'h7FFF_FFFF);
    // R7: cold spell then recovery
    drive("R7", 50, 0, 0, 0, 0, 0, 1, 32'h5151_5151);
    drive("R7", 50, 0, 0, 0, 0, 0, 1, 32'h5252_5252);
    drive("R7", 150, 0, 0, 0, 0, 0, 1, 32'h5353_5353);
    drive("R7", 150, 0, 0, 0, 0, 0, 1, 32'h5454_5454);
    // R9: untrusted agents try to lower the limit
    drive("R9", 150, 1, 5, 10, 0, 0, 1, 32'h9999_0001);
    drive("R9", 150, 1, 7, 0, 0, 0, 1, 32'h9999_0002);
    drive("R9", 150, 0, 0, 0, 0, 0, 1, 32'h9999_0003);
    // R8: trusted agent raises the limit above the running temperature
    drive("R8", 150, 1, 1, 300, 0, 0, 1, 32'h8888_0001);
    drive("R8", 150, 0, 0, 0, 0, 0, 1, 32'h8888_0002);
    drive("R8", 301, 1, 0, 301, 0, 0, 1, 32'h8888_0003);
    drive("R8", 302, 0, 0, 0, 0, 0, 1, 32'h8888_0004);
    drive("R8", 302, 0, 0, 0, 0, 0, 1, 32'h8888_0005);
    repeat (3) @(negedge clk);

    // R3: second session with a failing verdict
    applyReset();
    drive("R3", 900, 0, 0, 0, 0, 0, 1, 32'h3333_0000);
    drive("R3", 900, 0, 0, 0, 1, 0, 1, 32'h3333_0001);
    for (int i = 0; i < 5; i++) drive("R3", 1000, 0, 0, 0, (i == 2), 1, 1, 32'h3333_1000 + i);
    drive("R3", 1000, 1, 0, 10, 0, 0, 1, 32'h3333_2000);
    drive("R3", 1000, 0, 0, 0, 0, 0, 1, 32'h3333_2001);
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule